// File: doc/BRIEF.md
# Strobed Frequency-Select Latch

This block sits in front of a dual clock synthesizer and decides which stored setting each synthesizer runs from. A 4-bit pixel-clock select is captured by a strobe pin, and the capture mode is fixed at build time by a parameter. Captured values do not steer the synthesizer at once. A quiet-time counter, sized in system-clock cycles, must expire with no further capture before the captured index becomes the active pixel-clock selection. The active index reads a 16-entry pixel table. Each entry supplies an 8-bit feedback code, a 2-bit post-divider code and an external-source flag. When that flag is set, the pixel clock output is taken from the external frequency input instead of the synthesizer.

A second, 4-entry memory-clock table is indexed directly by a 2-bit select that is neither latched nor delayed. Both tables reset to computed defaults. Software or an init sequencer can rewrite them through a valid/ready programming port. That port is always ready: `prog_ready` is held high, so a beat is taken on every cycle `prog_valid` is high and no back-pressure is ever applied. The strobe, selects and programming port are all synchronous to `clk`.

Top module: `fsl_freq_select`

## Requirements
- R1: After an asynchronous reset (active-low `rst_n`), the active pixel index is `RESET_SEL` (0). Pixel entry i holds feedback (16*i+3) mod 256, post code i mod 4, and the external flag, which is set only for entry 15. Memory entry j holds feedback 64*j+9 and post code 3-j.
- R2: In rising mode (`STROBE_MODE`=STB_RISE), a write is the clock edge where `strobe` is sampled high after being sampled low, and `fs_sel` is captured there. Out of reset the previous strobe level counts as low.
- R3: In falling mode (STB_FALL), a write is the edge where `strobe` is sampled low after being sampled high, and `fs_sel` is captured there. The previous level counts as low out of reset.
- R4: In high-transparent mode (STB_HIGH), every edge at which `strobe` is sampled high is a write that captures `fs_sel`.
- R5: In low-transparent mode (STB_LOW), every edge at which `strobe` is sampled low is a write that captures `fs_sel`.
- R6: The active pixel index (`pix_index`) takes the last captured value exactly `QUIET_CYCLES` clock edges after the last write edge, provided no write falls in between. Any write restarts that count. At all other times `pix_index` holds its value.
- R7: `pix_fb` and `pix_pd` show the table entry addressed by `pix_index` in the same cycle that index is valid.
- R8: `pix_use_ext` shows the active entry's external flag. `vclk_out` equals `ext_freq_in` when the flag is 1 and `pll_vclk_in` when it is 0.
- R9: `mem_fb` and `mem_pd` show the memory-table entry addressed by `ms_sel` combinationally, with no latching and no quiet time.
- R10: `prog_ready` is always 1. A beat with `prog_is_mclk`=1 writes memory entry `prog_addr[1:0]` (feedback and post code only), but only when `prog_addr[3:2]` is 0. Otherwise the beat is ignored.
- R11: A beat with `prog_is_mclk`=0 writes pixel entry `prog_addr` with all three fields. If that entry is active, the new values appear on the pixel outputs in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Capture control for the pixel select |
| fs_sel | input | SEL_W (4) | Pixel-clock select bus, bit 0 is LSB |
| ms_sel | input | MSEL_W (2) | Memory-clock select, unlatched |
| pll_vclk_in | input | 1 | Synthesizer pixel clock |
| ext_freq_in | input | 1 | External frequency input |
| prog_valid | input | 1 | Programming beat valid |
| prog_ready | output | 1 | Programming beat accepted (always 1) |
| prog_is_mclk | input | 1 | 1 selects the memory table, 0 the pixel table |
| prog_addr | input | SEL_W (4) | Entry address |
| prog_fb | input | 8 | Feedback code to store |
| prog_pd | input | 2 | Post-divider code to store |
| prog_ext | input | 1 | External flag to store (pixel table only) |
| pix_index | output | SEL_W (4) | Active pixel-clock selection |
| pix_fb | output | 8 | Active pixel feedback code |
| pix_pd | output | 2 | Active pixel post-divider code |
| pix_use_ext | output | 1 | Active entry routes the external input |
| vclk_out | output | 1 | Selected pixel clock source |
| mem_fb | output | 8 | Selected memory-clock feedback code |
| mem_pd | output | 2 | Selected memory-clock post-divider code |

## Verification
A capture happens at the edge where the strobe condition is sampled. `pix_index` moves `QUIET_CYCLES` edges after the last capture edge. The pixel fields and `vclk_out` follow in that same cycle with no extra register, while the memory outputs follow `ms_sel` with zero delay. A table beat becomes visible one edge after it is accepted. The bench changes inputs only on falling clock edges. It updates a cycle-accurate expectation on each rising edge and compares every output on the next falling edge, so each result is checked in the exact cycle it is due. All four strobe modes run side by side from the same select stimulus.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  localparam int FB_W = 8;
  localparam int PD_W = 2;
  localparam int FULL_W = FB_W + PD_W + 1;

  typedef enum logic [1:0] {
    STB_RISE = 2'd0,
    STB_FALL = 2'd1,
    STB_HIGH = 2'd2,
    STB_LOW  = 2'd3
  } strobe_mode_e;

  // Reset contents of one table entry, packed as {ext, post, feedback}.
  function automatic logic [FULL_W-1:0] entry_default(input bit pix, input int unsigned idx);
    logic [FB_W-1:0] fb;
    logic [PD_W-1:0] pd;
    logic            ext;
    if (pix) begin
      fb  = FB_W'((idx * 16 + 3) % 256);
      pd  = PD_W'(idx % 4);
      ext = (idx == 15);
    end else begin
      fb  = FB_W'((idx * 64 + 9) % 256);
      pd  = PD_W'((3 - (idx % 4)) % 4);
      ext = 1'b0;
    end
    return {ext, pd, fb};
  endfunction

endpackage

// File: rtl/fsl_strobe_capture.sv
module fsl_strobe_capture #(
  parameter int                   SEL_W = 4,
  parameter fsl_pkg::strobe_mode_e MODE = fsl_pkg::STB_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [SEL_W-1:0] sel_in,
  output logic             wr_event,
  output logic [SEL_W-1:0] held_sel
);

  generate
    if (MODE == fsl_pkg::STB_RISE || MODE == fsl_pkg::STB_FALL) begin : g_edge
      logic strobe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
      end
      if (MODE == fsl_pkg::STB_RISE) begin : g_rise
        assign wr_event = strobe & ~strobe_q;
      end else begin : g_fall
        assign wr_event = ~strobe & strobe_q;
      end
    end else if (MODE == fsl_pkg::STB_HIGH) begin : g_high
      assign wr_event = strobe;
    end else begin : g_low
      assign wr_event = ~strobe;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_sel <= '0;
    else if (wr_event) held_sel <= sel_in;
  end

endmodule

// File: rtl/fsl_quiet_timer.sv
module fsl_quiet_timer #(
  parameter int QUIET_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_event,
  output logic commit
);

  localparam int CNT_W = $clog2(QUIET_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pending_q;

  assign commit = pending_q & ~wr_event & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pending_q <= 1'b0;
    end else if (wr_event) begin
      cnt_q     <= CNT_W'(QUIET_CYCLES);
      pending_q <= 1'b1;
    end else if (pending_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) pending_q <= 1'b0;
    end
  end

endmodule

// File: rtl/fsl_setting_table.sv
module fsl_setting_table #(
  parameter int DEPTH    = 16,
  parameter int AW       = 4,
  parameter int DATA_W   = 11,
  parameter bit PIX_KIND = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] ent [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam logic [fsl_pkg::FULL_W-1:0] DEF_FULL = fsl_pkg::entry_default(PIX_KIND, i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ent[i] <= DEF_FULL[DATA_W-1:0];
        else if (wr_en && wr_addr == AW'(i)) ent[i] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = ent[rd_addr];

endmodule

// File: rtl/fsl_freq_select.sv
module fsl_freq_select #(
  parameter int                    SEL_W        = 4,
  parameter int                    MSEL_W       = 2,
  parameter fsl_pkg::strobe_mode_e STROBE_MODE  = fsl_pkg::STB_RISE,
  parameter int                    QUIET_CYCLES = 5_000_000,
  parameter int                    RESET_SEL    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [SEL_W-1:0]  fs_sel,
  input  logic [MSEL_W-1:0] ms_sel,
  input  logic              pll_vclk_in,
  input  logic              ext_freq_in,
  input  logic              prog_valid,
  output logic              prog_ready,
  input  logic              prog_is_mclk,
  input  logic [SEL_W-1:0]  prog_addr,
  input  logic [7:0]        prog_fb,
  input  logic [1:0]        prog_pd,
  input  logic              prog_ext,
  output logic [SEL_W-1:0]  pix_index,
  output logic [7:0]        pix_fb,
  output logic [1:0]        pix_pd,
  output logic              pix_use_ext,
  output logic              vclk_out,
  output logic [7:0]        mem_fb,
  output logic [1:0]        mem_pd
);

  localparam int PIX_DEPTH = 1 << SEL_W;
  localparam int MEM_DEPTH = 1 << MSEL_W;
  localparam int PIX_W     = fsl_pkg::FULL_W;
  localparam int MEM_W     = fsl_pkg::FB_W + fsl_pkg::PD_W;

  logic             wr_event;
  logic [SEL_W-1:0] held_sel;
  logic             commit;
  logic [SEL_W-1:0] active_q;
  logic             pix_wr;
  logic             mem_wr;
  logic [PIX_W-1:0] pix_rd;
  logic [MEM_W-1:0] mem_rd;

  fsl_strobe_capture #(.SEL_W(SEL_W), .MODE(STROBE_MODE)) u_cap (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sel_in(fs_sel),
    .wr_event(wr_event), .held_sel(held_sel)
  );

  fsl_quiet_timer #(.QUIET_CYCLES(QUIET_CYCLES)) u_quiet (
    .clk(clk), .rst_n(rst_n), .wr_event(wr_event), .commit(commit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active_q <= SEL_W'(RESET_SEL);
    else if (commit) active_q <= held_sel;
  end

  assign prog_ready = 1'b1;
  assign pix_wr = prog_valid & ~prog_is_mclk;
  assign mem_wr = prog_valid & prog_is_mclk & (prog_addr[SEL_W-1:MSEL_W] == '0);

  fsl_setting_table #(.DEPTH(PIX_DEPTH), .AW(SEL_W), .DATA_W(PIX_W), .PIX_KIND(1'b1)) u_pix_tab (
    .clk(clk), .rst_n(rst_n), .wr_en(pix_wr), .wr_addr(prog_addr),
    .wr_data({prog_ext, prog_pd, prog_fb}), .rd_addr(active_q), .rd_data(pix_rd)
  );

  fsl_setting_table #(.DEPTH(MEM_DEPTH), .AW(MSEL_W), .DATA_W(MEM_W), .PIX_KIND(1'b0)) u_mem_tab (
    .clk(clk), .rst_n(rst_n), .wr_en(mem_wr), .wr_addr(prog_addr[MSEL_W-1:0]),
    .wr_data({prog_pd, prog_fb}), .rd_addr(ms_sel), .rd_data(mem_rd)
  );

  assign pix_index   = active_q;
  assign pix_fb      = pix_rd[7:0];
  assign pix_pd      = pix_rd[9:8];
  assign pix_use_ext = pix_rd[10];
  assign vclk_out    = pix_use_ext ? ext_freq_in : pll_vclk_in;
  assign mem_fb      = mem_rd[7:0];
  assign mem_pd      = mem_rd[9:8];

endmodule

// File: rtl/fsl_freq_select_chk.sv
module fsl_freq_select_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] fs_sel,
  input logic             prog_valid,
  input logic             prog_ready,
  input logic             prog_is_mclk,
  input logic [SEL_W-1:0] prog_addr,
  input logic [7:0]       prog_fb,
  input logic [SEL_W-1:0] pix_index,
  input logic [7:0]       pix_fb,
  input logic             wr_event,
  input logic             commit,
  input logic [SEL_W-1:0] held_sel
);

  AST_PROG_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ready); // R10

  AST_CAPTURE_TAKES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_event |=> held_sel == $past(fs_sel)); // R2

  AST_NO_COMMIT_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_event |-> !commit); // R6

  AST_INDEX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(pix_index)); // R6

  AST_COMMIT_LOADS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> pix_index == $past(held_sel)); // R6

  AST_PROG_ACTIVE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && !prog_is_mclk && prog_addr == pix_index && !commit)
      |=> pix_fb == $past(prog_fb)); // R11

endmodule

bind fsl_freq_select fsl_freq_select_chk #(.SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fs_sel(fs_sel),
  .prog_valid(prog_valid), .prog_ready(prog_ready), .prog_is_mclk(prog_is_mclk),
  .prog_addr(prog_addr), .prog_fb(prog_fb), .pix_index(pix_index), .pix_fb(pix_fb),
  .wr_event(wr_event), .commit(commit), .held_sel(held_sel)
);

// File: tb/fsl_freq_select_tb.sv
`timescale 1ns/1ps
module fsl_freq_select_tb_top;

  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       p = 1'b0;
  logic [3:0] stb;
  logic [3:0] fs_sel = '0;
  logic [1:0] ms_sel = '0;
  logic       pll_in = 1'b0, ext_in = 1'b0;
  logic       pv = 1'b0, pmc = 1'b0, pext = 1'b0;
  logic [3:0] paddr = '0;
  logic [7:0] pfb = '0;
  logic [1:0] ppd = '0;

  logic [3:0] o_idx [4];
  logic [7:0] o_fb [4], o_mfb [4];
  logic [1:0] o_pd [4], o_mpd [4];
  logic       o_ext [4], o_vclk [4], o_rdy [4];

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // rise and high see the pulse level, fall and low see it inverted
  assign stb = {~p, p, ~p, p};

  always #5 clk = ~clk;

  fsl_freq_select #(.STROBE_MODE(fsl_pkg::STB_RISE), .QUIET_CYCLES(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobe(stb[0]), .fs_sel(fs_sel), .ms_sel(ms_sel),
    .pll_vclk_in(pll_in), .ext_freq_in(ext_in), .prog_valid(pv), .prog_ready(o_rdy[0]),
    .prog_is_mclk(pmc), .prog_addr(paddr), .prog_fb(pfb), .prog_pd(ppd), .prog_ext(pext),
    .pix_index(o_idx[0]), .pix_fb(o_fb[0]), .pix_pd(o_pd[0]), .pix_use_ext(o_ext[0]),
    .vclk_out(o_vclk[0]), .mem_fb(o_mfb[0]), .mem_pd(o_mpd[0]));

  fsl_freq_select #(.STROBE_MODE(fsl_pkg::STB_FALL), .QUIET_CYCLES(Q)) dut_fall (
    .clk(clk), .rst_n(rst_n), .strobe(stb[1]), .fs_sel(fs_sel), .ms_sel(ms_sel),
    .pll_vclk_in(pll_in), .ext_freq_in(ext_in), .prog_valid(pv), .prog_ready(o_rdy[1]),
    .prog_is_mclk(pmc), .prog_addr(paddr), .prog_fb(pfb), .prog_pd(ppd), .prog_ext(pext),
    .pix_index(o_idx[1]), .pix_fb(o_fb[1]), .pix_pd(o_pd[1]), .pix_use_ext(o_ext[1]),
    .vclk_out(o_vclk[1]), .mem_fb(o_mfb[1]), .mem_pd(o_mpd[1]));

  fsl_freq_select #(.STROBE_MODE(fsl_pkg::STB_HIGH), .QUIET_CYCLES(Q)) dut_high (
    .clk(clk), .rst_n(rst_n), .strobe(stb[2]), .fs_sel(fs_sel), .ms_sel(ms_sel),
    .pll_vclk_in(pll_in), .ext_freq_in(ext_in), .prog_valid(pv), .prog_ready(o_rdy[2]),
    .prog_is_mclk(pmc), .prog_addr(paddr), .prog_fb(pfb), .prog_pd(ppd), .prog_ext(pext),
    .pix_index(o_idx[2]), .pix_fb(o_fb[2]), .pix_pd(o_pd[2]), .pix_use_ext(o_ext[2]),
    .vclk_out(o_vclk[2]), .mem_fb(o_mfb[2]), .mem_pd(o_mpd[2]));

  fsl_freq_select #(.STROBE_MODE(fsl_pkg::STB_LOW), .QUIET_CYCLES(Q)) dut_low (
    .clk(clk), .rst_n(rst_n), .strobe(stb[3]), .fs_sel(fs_sel), .ms_sel(ms_sel),
    .pll_vclk_in(pll_in), .ext_freq_in(ext_in), .prog_valid(pv), .prog_ready(o_rdy[3]),
    .prog_is_mclk(pmc), .prog_addr(paddr), .prog_fb(pfb), .prog_pd(ppd), .prog_ext(pext),
    .pix_index(o_idx[3]), .pix_fb(o_fb[3]), .pix_pd(o_pd[3]), .pix_use_ext(o_ext[3]),
    .vclk_out(o_vclk[3]), .mem_fb(o_mfb[3]), .mem_pd(o_mpd[3]));

  // ---------------- expectation state ----------------
  logic [10:0] e_pix [16];
  logic [9:0]  e_mem [4];
  logic [3:0]  e_act [4], e_held [4];
  int          e_cnt [4];
  bit          e_pend [4], e_prev [4];
  string       mode_tag [4] = '{"R2", "R3", "R4", "R5"};

  function automatic logic [10:0] pix_def(int i);   // R1
    return {1'(i == 15), 2'(i % 4), 8'((16 * i + 3) % 256)};
  endfunction

  function automatic logic [9:0] mem_def(int j);    // R1
    return {2'(3 - j), 8'(64 * j + 9)};
  endfunction

  function automatic bit is_write(int m, bit s, bit pv_s);  // R2 R3 R4 R5
    case (m)
      0:       return s && !pv_s;
      1:       return !s && pv_s;
      2:       return s;
      default: return !s;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) e_pix[i] = pix_def(i);
    for (int j = 0; j < 4; j++) e_mem[j] = mem_def(j);
    for (int m = 0; m < 4; m++) begin
      e_act[m] = '0; e_held[m] = '0; e_cnt[m] = 0; e_pend[m] = 0; e_prev[m] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      for (int m = 0; m < 4; m++) begin
        if (is_write(m, stb[m], e_prev[m])) begin
          e_held[m] = fs_sel; e_cnt[m] = Q; e_pend[m] = 1;
        end else if (e_pend[m]) begin
          if (e_cnt[m] == 1) begin e_act[m] = e_held[m]; e_pend[m] = 0; end
          e_cnt[m]--;
        end
        e_prev[m] = stb[m];
      end
      if (pv) begin
        if (!pmc) e_pix[paddr] = {pext, ppd, pfb};
        else if (paddr[3:2] == 2'b00) e_mem[paddr[1:0]] = {ppd, pfb};
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    for (int m = 0; m < 4; m++) begin
      logic [10:0] e;
      e = e_pix[e_act[m]];
      chk({mode_tag[m], "/R6"}, "pix_index", o_idx[m], e_act[m]);
      chk("R7", "pix_fb", o_fb[m], e[7:0]);
      chk("R7", "pix_pd", o_pd[m], e[9:8]);
      chk("R8", "pix_use_ext", o_ext[m], e[10]);
      chk("R8", "vclk_out", o_vclk[m], e[10] ? ext_in : pll_in);
      chk("R9", "mem_fb", o_mfb[m], e_mem[ms_sel][7:0]);
      chk("R9", "mem_pd", o_mpd[m], e_mem[ms_sel][9:8]);
      chk("R10", "prog_ready", o_rdy[m], 1);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic pulse(input logic [3:0] sel, input int len);
    fs_sel = sel; p = 1'b1;
    for (int k = 0; k < len; k++) step();
    p = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state on every port
    for (int m = 0; m < 4; m++) begin
      chk("R1", "reset pix_index", o_idx[m], 0);
      chk("R1", "reset pix_fb", o_fb[m], 3);
      chk("R1", "reset pix_pd", o_pd[m], 0);
    end
    for (int j = 0; j < 4; j++) begin
      ms_sel = 2'(j);
      #1;
      chk("R1", "reset mem_fb", o_mfb[0], 64 * j + 9);
      chk("R1", "reset mem_pd", o_mpd[0], 3 - j);
    end
    ms_sel = '0;
    step();

    // R6: single one-cycle pulse, watch the full quiet window
    pulse(4'd5, 1);
    repeat (Q + 2) step();
    chk("R6", "committed rise index", o_idx[0], 5);

    // R6: a second write inside the window restarts the count
    pulse(4'd3, 1);
    repeat (Q - 2) step();
    pulse(4'd9, 2);
    repeat (Q + 2) step();
    chk("R4", "high mode keeps last value", o_idx[2], 9);

    // R8: entry 15 carries the external flag
    pulse(4'd15, 1);
    repeat (Q + 1) step();
    ext_in = 1'b1; pll_in = 1'b0;
    step();
    chk("R8", "vclk from external", o_vclk[0], 1);

    // R11: rewrite the active entry, external flag cleared
    pv = 1'b1; pmc = 1'b0; paddr = 4'd15; pfb = 8'hA5; ppd = 2'd1; pext = 1'b0;
    step();
    pv = 1'b0;
    chk("R11", "active entry rewrite fb", o_fb[0], 8'hA5);
    chk("R11", "vclk back to pll", o_vclk[0], 0);

    // R10: memory write with upper address bits set is ignored
    pv = 1'b1; pmc = 1'b1; paddr = 4'd5; pfb = 8'h11; ppd = 2'd0; ms_sel = 2'd1;
    step();
    pv = 1'b0;
    chk("R10", "upper-address mem write ignored", o_mfb[0], 73);
    pv = 1'b1; paddr = 4'd1;
    step();
    pv = 1'b0;
    chk("R10", "mem write lands", o_mfb[0], 8'h11);
    step();

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      step();
      if (p) p = ($urandom % 3) != 0;
      else   p = ($urandom % 12) == 0;
      fs_sel = 4'($urandom);
      ms_sel = 2'($urandom);
      pll_in = 1'($urandom);
      ext_in = 1'($urandom);
      pv     = ($urandom % 8) == 0;
      pmc    = 1'($urandom);
      paddr  = 4'($urandom);
      pfb    = 8'($urandom);
      ppd    = 2'($urandom);
      pext   = 1'($urandom);
    end
    pv = 1'b0; p = 1'b0;
    repeat (Q + 3) step();
    finish_run();
  end

endmodule